// File: doc/BRIEF.md
# Echo-Path Attenuator Steering

This block sits in a hands-free voice path and picks one of two 6 dB attenuators for each sample. One attenuator sits on the receive input, which feeds the loudspeaker. The other sits on the send output, which comes from the microphone side. Each path has a level detector with hangover that reports speech activity. The choice depends on both activity flags together, not on one path's threshold. While the function is enabled, exactly one attenuator is applied.

The block takes one signed 16-bit linear sample per path on each pulse of `smp_stb`. It returns both streams, registered, with the chosen gain applied. Two flags report which attenuator is in force. The active-low pin `att_en_n` turns the function off. When it is off, both samples pass through unchanged.

The steering state machine has three states:

- `ST_BYPASS`: the function is disabled; neither attenuator is applied.
- `ST_RX_ATT`: the receive-input attenuator is applied.
- `ST_TX_ATT`: the send-output attenuator is applied.

Transitions are evaluated only on a strobe and can go from any state to any state:

- `att_en_n` high leads to `ST_BYPASS`.
- With `att_en_n` low, "receive active and send quiet" leads to `ST_TX_ATT`.
- Every other activity combination leads to `ST_RX_ATT`: receive quiet, or both paths active.

Without a strobe, the state and all outputs hold.

Top module: `att_steer_top`

## Requirements
- R1: While `rst_n` is low, `rx_out` and `tx_out` are 0 and both attenuator flags are 0 (state `ST_BYPASS`).
- R2: A strobe with `att_en_n` high makes the next cycle show `rx_out = rx_in` and `tx_out = tx_in` as sampled on that strobe, with both flags 0.
- R3: A strobe with `att_en_n` low, receive active and send not active sets `tx_att_on`=1 and `rx_att_on`=0. The send sample is halved and the receive sample passes unchanged.
- R4: A strobe with `att_en_n` low and receive not active sets `rx_att_on`=1 and `tx_att_on`=0. The receive sample is halved and the send sample passes unchanged.
- R5: A strobe with `att_en_n` low and both paths active also selects the receive-input attenuator (`rx_att_on`=1, `tx_att_on`=0).
- R6: The 6 dB loss is an arithmetic right shift by one bit, rounding toward minus infinity. Examples: -3 gives -2, -1 gives -1, and -32768 gives -16384.
- R7: A path is active on a strobe when its sample magnitude is strictly greater than `lvl_thr`. A magnitude equal to `lvl_thr` does not count. The magnitude of -32768 is 32768.
- R8: After its last strobe above threshold, a path stays active for exactly `hang_len` further strobes, then goes inactive. The detectors run whether or not the function is enabled.
- R9: In a cycle without `smp_stb`, `rx_out`, `tx_out` and both flags keep their values.
- R10: After any strobe with `att_en_n` low, exactly one of `rx_att_on` and `tx_att_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle pulse marking a new sample pair |
| att_en_n | input | 1 | Attenuator function enable, active low |
| lvl_thr | input | 16 | Activity threshold on sample magnitude |
| hang_len | input | 8 | Hangover length in strobes |
| rx_in | input | 16 | Receive-path sample, signed |
| tx_in | input | 16 | Send-path sample, signed |
| rx_out | output | 16 | Receive-path sample after steering gain |
| tx_out | output | 16 | Send-path sample after steering gain |
| rx_att_on | output | 1 | Receive-input attenuator applied |
| tx_att_on | output | 1 | Send-output attenuator applied |

## Verification
The assertions assume the following about the inputs:

- `smp_stb` is a single-cycle pulse.
- `lvl_thr` and `hang_len` are stable across the strobes of a detection episode.

The hangover property only counts strobes, so changing `hang_len` in the middle of a countdown would make the reference expectation ambiguous. For that reason, the stimulus sets both controls once after reset and never changes them. Strobes are separated by idle gaps of varying length, so the hold behaviour between samples is covered alongside the steering decisions.

// File: rtl/att_steer_pkg.sv
package att_steer_pkg;

    localparam int NPATH   = 2;
    localparam int PATH_RX = 0;
    localparam int PATH_TX = 1;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_RX_ATT = 2'd1,
        ST_TX_ATT = 2'd2
    } steer_st_t;

endpackage

// File: rtl/lvl_detect.sv
module lvl_detect #(
    parameter int DW = 16,
    parameter int HW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic signed [DW-1:0] smp,
    input  logic        [DW-1:0] thr,
    input  logic        [HW-1:0] hang,
    output logic                 act_nx,
    output logic                 act
);

    localparam int MW = DW + 1;

    logic [MW-1:0] mag;
    logic          over;
    logic [HW-1:0] hcnt;
    logic [HW-1:0] hcnt_nx;

    always_comb begin
        if (smp[DW-1]) begin
            mag = ~{smp[DW-1], smp} + MW'(1);
        end else begin
            mag = {1'b0, smp};
        end
        over    = (mag > {1'b0, thr});
        act_nx  = over || (hcnt != '0);
        if (over) begin
            hcnt_nx = hang;
        end else if (hcnt != '0) begin
            hcnt_nx = hcnt - HW'(1);
        end else begin
            hcnt_nx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            act  <= 1'b0;
        end else if (stb) begin
            hcnt <= hcnt_nx;
            act  <= act_nx;
        end
    end

    // a sample above threshold always marks the path active
    assert_loud_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && over) |=> act);

    // with the hangover spent and a quiet sample, activity drops
    assert_hang_expire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !over && hcnt == '0) |=> !act);

endmodule

// File: rtl/steer_fsm.sv
module steer_fsm
    import att_steer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb,
    input  logic      en_n,
    input  logic      rx_act_nx,
    input  logic      tx_act_nx,
    output steer_st_t st_nx,
    output logic      rx_att_on,
    output logic      tx_att_on
);

    steer_st_t st;

    always_comb begin
        st_nx = st;
        if (stb) begin
            if (en_n) begin
                st_nx = ST_BYPASS;
            end else if (rx_act_nx && !tx_act_nx) begin
                st_nx = ST_TX_ATT;
            end else begin
                st_nx = ST_RX_ATT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_BYPASS;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        unique case (st)
            ST_BYPASS: begin
                rx_att_on = 1'b0;
                tx_att_on = 1'b0;
            end
            ST_RX_ATT: begin
                rx_att_on = 1'b1;
                tx_att_on = 1'b0;
            end
            ST_TX_ATT: begin
                rx_att_on = 1'b0;
                tx_att_on = 1'b1;
            end
            default: begin
                rx_att_on = 1'b0;
                tx_att_on = 1'b0;
            end
        endcase
    end

    // far-end-only talk must steer the loss onto the send side
    assert_far_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !en_n && rx_act_nx && !tx_act_nx) |=> (tx_att_on && !rx_att_on));

    // double talk keeps the loss on the receive side
    assert_double_talk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !en_n && rx_act_nx && tx_act_nx) |=> (rx_att_on && !tx_att_on));

endmodule

// File: rtl/gain_stage.sv
module gain_stage #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic                 att_on,
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] y
);

    logic [DW+1:0] x_ext;
    logic [DW+1:0] y_dbl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y <= '0;
        end else if (stb) begin
            y <= att_on ? (x >>> 1) : x;
        end
    end

    assign x_ext = {{2{x[DW-1]}}, x};
    assign y_dbl = {y[DW-1], y, 1'b0};

    // halved output doubled back lies within one LSB below the input
    assert_halve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && att_on) |=> (($past(x_ext) - y_dbl) == '0 ||
                             ($past(x_ext) - y_dbl) == (DW+2)'(1)));

endmodule

// File: rtl/att_steer_top.sv
module att_steer_top
    import att_steer_pkg::*;
#(
    parameter int DW = 16,
    parameter int HW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic                 att_en_n,
    input  logic        [DW-1:0] lvl_thr,
    input  logic        [HW-1:0] hang_len,
    input  logic signed [DW-1:0] rx_in,
    input  logic signed [DW-1:0] tx_in,
    output logic signed [DW-1:0] rx_out,
    output logic signed [DW-1:0] tx_out,
    output logic                 rx_att_on,
    output logic                 tx_att_on
);

    logic signed [DW-1:0] p_in  [NPATH];
    logic signed [DW-1:0] p_out [NPATH];
    logic                 p_act_nx [NPATH];
    logic                 p_act    [NPATH];
    logic                 p_att    [NPATH];
    steer_st_t            st_nx;

    assign p_in[PATH_RX] = rx_in;
    assign p_in[PATH_TX] = tx_in;
    assign p_att[PATH_RX] = (st_nx == ST_RX_ATT);
    assign p_att[PATH_TX] = (st_nx == ST_TX_ATT);

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        lvl_detect #(.DW(DW), .HW(HW)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (smp_stb),
            .smp    (p_in[g]),
            .thr    (lvl_thr),
            .hang   (hang_len),
            .act_nx (p_act_nx[g]),
            .act    (p_act[g])
        );

        gain_stage #(.DW(DW)) u_gain (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (smp_stb),
            .att_on (p_att[g]),
            .x      (p_in[g]),
            .y      (p_out[g])
        );
    end

    steer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (smp_stb),
        .en_n      (att_en_n),
        .rx_act_nx (p_act_nx[PATH_RX]),
        .tx_act_nx (p_act_nx[PATH_TX]),
        .st_nx     (st_nx),
        .rx_att_on (rx_att_on),
        .tx_att_on (tx_att_on)
    );

    assign rx_out = p_out[PATH_RX];
    assign tx_out = p_out[PATH_TX];

    // disabled function passes both samples straight through
    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && att_en_n) |=> (rx_out == $past(rx_in) && tx_out == $past(tx_in)
                                   && !rx_att_on && !tx_att_on));

    // enabled function always has exactly one attenuator in force
    assert_one_att_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !att_en_n) |=> (rx_att_on != tx_att_on));

    // gain and flags never move between strobes
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(rx_out) && $stable(tx_out)
                      && $stable(rx_att_on) && $stable(tx_att_on)));

endmodule

// File: tb/att_steer_top_bench.sv
module att_steer_top_bench;

    localparam int THR  = 1000;
    localparam int HANG = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_stb = 1'b0;
    logic               att_en_n = 1'b1;
    logic        [15:0] lvl_thr = 16'(THR);
    logic        [7:0]  hang_len = 8'(HANG);
    logic signed [15:0] rx_in = '0;
    logic signed [15:0] tx_in = '0;
    logic signed [15:0] rx_out;
    logic signed [15:0] tx_out;
    logic               rx_att_on;
    logic               tx_att_on;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int e_rx = 0, e_tx = 0;
    bit e_rf = 0, e_tf = 0;
    int hc_r = 0, hc_t = 0;

    always #10 clk = ~clk;

    att_steer_top u_att_steer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .att_en_n  (att_en_n),
        .lvl_thr   (lvl_thr),
        .hang_len  (hang_len),
        .rx_in     (rx_in),
        .tx_in     (tx_in),
        .rx_out    (rx_out),
        .tx_out    (tx_out),
        .rx_att_on (rx_att_on),
        .tx_att_on (tx_att_on)
    );

    function automatic int half_floor(int v);
        if (v >= 0) return v / 2;
        return -((-v + 1) / 2);
    endfunction

    function automatic int magn(int v);
        return (v < 0) ? -v : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_rx = 0; e_tx = 0; e_rf = 0; e_tf = 0; hc_r = 0; hc_t = 0;
        end else if (smp_stb) begin
            int r, t;
            bit ovr, ovt, ar, at;
            r = int'(rx_in);
            t = int'(tx_in);
            ovr = magn(r) > THR;
            ovt = magn(t) > THR;
            ar = ovr || (hc_r != 0);
            at = ovt || (hc_t != 0);
            hc_r = ovr ? HANG : (hc_r > 0 ? hc_r - 1 : 0);
            hc_t = ovt ? HANG : (hc_t > 0 ? hc_t - 1 : 0);
            if (att_en_n) begin
                e_rf = 0; e_tf = 0; e_rx = r; e_tx = t;
            end else if (ar && !at) begin
                e_rf = 0; e_tf = 1; e_rx = r; e_tx = half_floor(t);
            end else begin
                e_rf = 1; e_tf = 0; e_rx = half_floor(r); e_tx = t;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (int'(rx_out) != e_rx || int'(tx_out) != e_tx ||
                rx_att_on != e_rf || tx_att_on != e_tf) begin
                n_bad++;
                $display("FAIL %s: got rx=%0d tx=%0d rf=%0b tf=%0b, expected rx=%0d tx=%0d rf=%0b tf=%0b",
                         cur_req, rx_out, tx_out, rx_att_on, tx_att_on,
                         e_rx, e_tx, e_rf, e_tf);
            end
        end
    end

    task automatic send(input int r, input int t, input bit en_n, input int gap);
        @(negedge clk);
        rx_in    = 16'(r);
        tx_in    = 16'(t);
        att_en_n = en_n;
        smp_stb  = 1'b1;
        @(negedge clk);
        smp_stb  = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R2";
        send(5000, -7000, 1, 1);
        send(-3, 9, 1, 0);
        send(-32768, 32767, 1, 2);
        for (int i = 0; i < 5; i++) send(10 * i, -10 * i, 1, 0);

        cur_req = "R4";
        send(-3, 2500, 0, 1);
        send(7, -3000, 0, 0);
        send(0, 0, 0, 1);
        send(999, -999, 0, 0);

        cur_req = "R3";
        send(4000, 11, 0, 0);
        send(-4000, -5, 0, 1);
        send(2000, 999, 0, 0);

        cur_req = "R5";
        send(3000, 3000, 0, 0);
        send(-30000, 1500, 0, 2);
        for (int i = 0; i < 5; i++) send(0, 0, 0, 0);

        cur_req = "R7";
        send(1000, 0, 0, 0);
        send(-1000, 0, 0, 0);
        send(1001, 0, 0, 0);
        for (int i = 0; i < 5; i++) send(0, 0, 0, 0);
        send(-1001, 0, 0, 1);
        for (int i = 0; i < 5; i++) send(0, 0, 0, 0);

        cur_req = "R8";
        send(6000, 0, 0, 0);
        for (int i = 0; i < 6; i++) send(3, -3, 0, i % 3);
        send(6000, 0, 1, 0);
        send(0, 0, 1, 0);
        send(0, 0, 0, 0);
        send(0, 0, 0, 0);
        send(0, 0, 0, 0);

        cur_req = "R6";
        send(-3, 0, 0, 0);
        send(-1, 0, 0, 0);
        send(1, 0, 0, 0);
        send(-32768, -5, 0, 0);
        send(-32768, 2000, 0, 0);
        send(-32768, -32767, 0, 0);
        for (int i = 0; i < 5; i++) send(0, 0, 0, 0);

        cur_req = "R10";
        for (int i = 0; i < 12; i++)
            send((i % 3 == 0) ? 5000 : 0, (i % 4 == 0) ? -5000 : 0, (i % 5 == 4), 0);

        cur_req = "R9";
        send(4000, -9, 0, 7);
        send(-17, 4000, 0, 11);
        send(4000, 4000, 1, 5);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule